// File: doc/BRIEF.md
# Modem Status Tracker with Loopback

This block holds the modem status byte of a 16550-style serial port. Each clock it samples four modem input lines that have already been synchronised: carrier detect, ring, data-set-ready and clear-to-send. It remembers the previous sample of each line. When a line changes, the block sets a sticky change flag for that line. The ring line is the exception: its flag is set only when ring falls. A read strobe from the host side returns the status byte and clears the change flags. A line change that lands in the same cycle as the read still leaves its flag set, so no change is lost.

The block also holds the five-bit modem control register. When the loopback bit of that register is set, the status byte no longer shows the pins. It shows four control bits routed back through a fixed, crossed mapping, and the four change flags read as zero. A separate output reports whether any change flag is stored, and the interrupt logic of the port uses it.

Top module: `msr_core`

## Requirements
- R1: After synchronous reset, `stat_rdata` reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), `ctl_q` reads 0x08, and `delta_pend` is 0.
- R2: `modem_in` packs the lines as bit 3 carrier, bit 2 ring, bit 1 data-set-ready, bit 0 clear-to-send. Outside loopback, the value on `modem_in` appears in `stat_rdata[7:4]` one clock edge later.
- R3: A change of carrier, data-set-ready or clear-to-send between two samples sets change flag bit 3, bit 1 or bit 0 of `stat_rdata`. The flag stays set until it is cleared by a read.
- R4: A ring fall (1 to 0) sets change flag bit 2. A ring rise leaves bit 2 unchanged.
- R5: Outside loopback, a clock edge with `stat_rd` high clears all four change flags and keeps the line bits.
- R6: A line change sampled on the same edge as a clearing read leaves that line's change flag set.
- R7: `delta_pend` is high exactly when at least one stored change flag is set.
- R8: A clock edge with `ctl_wr` high stores `ctl_wdata[4:0]` in `ctl_q`. Higher write bits are dropped.
- R9: With `ctl_q[4]` (loopback) set, `stat_rdata` reads bit 7 = `ctl_q[3]`, bit 6 = `ctl_q[2]`, bit 5 = `ctl_q[0]`, bit 4 = `ctl_q[1]`, and bits 3:0 read 0.
- R10: In loopback, `stat_rd` does not clear the stored change flags. They reappear when loopback is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the modem control register |
| ctl_wdata | input | DATA_W | Write data for the control register |
| ctl_q | output | 5 | Stored modem control register |
| stat_rd | input | 1 | Read strobe for the status byte; clears change flags outside loopback |
| modem_in | input | 4 | Synchronised modem lines {carrier, ring, dsr, cts} |
| stat_rdata | output | DATA_W | Status byte, zero-extended |
| delta_pend | output | 1 | Some change flag is stored |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, control reset value 0x08 and line reset value 0xB in the `modem_in` packing. These defaults put the reset byte 0xB0 and every loopback mapping within direct reach of a byte compare. The table walks rising and falling edges of every line, including a read that coincides with a new change. Directed tests cover loopback reads that must not clear stored flags, control writes with high bits set, and a reset in the middle of a run.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;

    localparam int LINE_N = 4;
    localparam int CTL_W  = 5;

    // line indices inside a packed line vector
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    // control register bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    typedef struct packed {
        mline_t lines;
        logic [LINE_N-1:0] delta;
    } mstat_t;

    // crossed routing of control outputs onto status inputs
    function automatic mline_t loop_lines(input logic [CTL_W-1:0] c);
        mline_t m;
        m.dcd = c[CB_OUT2];
        m.ri  = c[CB_OUT1];
        m.dsr = c[CB_DTR];
        m.cts = c[CB_RTS];
        return m;
    endfunction

endpackage

// File: rtl/msr_ctl_reg.sv
`timescale 1ns/1ps
module msr_ctl_reg
    import msr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [CTL_W-1:0] CTL_RST = 5'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= CTL_RST;
        else if (wr)
            ctl <= wdata[CTL_W-1:0];
    end
endmodule

// File: rtl/msr_line_track.sv
`timescale 1ns/1ps
module msr_line_track
    import msr_pkg::*;
#(
    parameter logic [LINE_N-1:0] LINE_RST = 4'b1011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_N-1:0] pins,
    input  logic              clr,
    output logic [LINE_N-1:0] line_q,
    output logic [LINE_N-1:0] delta_q
);
    logic [LINE_N-1:0] hit;
    logic [LINE_N-1:0] delta_d;

    for (genvar i = 0; i < LINE_N; i++) begin : g_edge
        if (i == IDX_RI) begin : g_trail
            assign hit[i] = line_q[i] & ~pins[i];
        end else begin : g_any
            assign hit[i] = line_q[i] ^ pins[i];
        end
    end

    // a fresh change wins over a clearing read in the same cycle
    assign delta_d = (clr ? '0 : delta_q) | hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= LINE_RST;
            delta_q <= '0;
        end else begin
            line_q  <= pins;
            delta_q <= delta_d;
        end
    end
endmodule

// File: rtl/msr_read_view.sv
`timescale 1ns/1ps
module msr_read_view
    import msr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [CTL_W-1:0]  ctl,
    input  logic [LINE_N-1:0] line_q,
    input  logic [LINE_N-1:0] delta_q,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              clr
);
    mstat_t view;

    always_comb begin
        if (ctl[CB_LOOP]) begin
            view.lines = loop_lines(ctl);
            view.delta = '0;
        end else begin
            view.lines = mline_t'(line_q);
            view.delta = delta_q;
        end
    end

    assign rdata = DATA_W'(view);
    assign clr   = rd & ~ctl[CB_LOOP];
endmodule

// File: rtl/msr_core.sv
`timescale 1ns/1ps
module msr_core
    import msr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [CTL_W-1:0]  CTL_RST  = 5'h08,
    parameter logic [LINE_N-1:0] LINE_RST = 4'b1011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic              stat_rd,
    input  logic [LINE_N-1:0] modem_in,
    output logic [DATA_W-1:0] stat_rdata,
    output logic              delta_pend
);
    logic [LINE_N-1:0] line_q;
    logic [LINE_N-1:0] delta_q;
    logic              clr;

    msr_ctl_reg #(.DATA_W(DATA_W), .CTL_RST(CTL_RST)) u_ctl (
        .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .ctl(ctl_q)
    );

    msr_line_track #(.LINE_RST(LINE_RST)) u_track (
        .clk(clk), .rst(rst), .pins(modem_in), .clr(clr),
        .line_q(line_q), .delta_q(delta_q)
    );

    msr_read_view #(.DATA_W(DATA_W)) u_view (
        .ctl(ctl_q), .line_q(line_q), .delta_q(delta_q), .rd(stat_rd),
        .rdata(stat_rdata), .clr(clr)
    );

    assign delta_pend = |delta_q;
endmodule

// File: rtl/msr_core_chk.sv
`timescale 1ns/1ps
module msr_core_chk
    import msr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic [CTL_W-1:0]  ctl_q,
    input logic              stat_rd,
    input logic [LINE_N-1:0] modem_in,
    input logic [DATA_W-1:0] stat_rdata,
    input logic              delta_pend
);
    // R7: pending flag agrees with visible flags outside loopback
    p_pend_or_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[CB_LOOP] |-> (delta_pend == (|stat_rdata[3:0])));

    // R8: control write lands one edge later
    p_ctl_store_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_q == $past(ctl_wdata[CTL_W-1:0])));

    // R5: read with steady pins leaves no flag
    p_read_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !ctl_wr && !ctl_q[CB_LOOP] && modem_in == stat_rdata[7:4])
        |=> (stat_rdata[3:0] == 4'h0));

    // R3: a flag holds without a read
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd && !ctl_wr && !ctl_q[CB_LOOP] && stat_rdata[3]) |=> stat_rdata[3]);

    // R10: loopback never drops a stored flag
    p_loop_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[CB_LOOP] && delta_pend) |=> delta_pend);

    // R4: a ring rise alone raises no ring flag
    p_ri_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd && !ctl_wr && !ctl_q[CB_LOOP] && !stat_rdata[2]
         && !stat_rdata[6] && modem_in[IDX_RI]) |=> !stat_rdata[2]);
endmodule

bind msr_core msr_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .stat_rd(stat_rd), .modem_in(modem_in),
    .stat_rdata(stat_rdata), .delta_pend(delta_pend)
);

// File: tb/msr_core_tb_top.sv
`timescale 1ns/1ps
module msr_core_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic [4:0] ctl_q;
    logic       stat_rd;
    logic [3:0] modem_in;
    logic [7:0] stat_rdata;
    logic       delta_pend;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    msr_core dut_i (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .stat_rd(stat_rd), .modem_in(modem_in),
        .stat_rdata(stat_rdata), .delta_pend(delta_pend)
    );

    // {pins[3:0], read, expected status byte after the edge}
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        {4'b1011, 1'b0, 8'hB0},  // R2 steady
        {4'b0011, 1'b0, 8'h38},  // R3 carrier drop
        {4'b0011, 1'b1, 8'h30},  // R5 clear
        {4'b0111, 1'b0, 8'h70},  // R4 ring rise: no flag
        {4'b0011, 1'b0, 8'h34},  // R4 ring fall
        {4'b0010, 1'b1, 8'h21},  // R6 cts drop during read
        {4'b0000, 1'b0, 8'h03},  // R3 dsr drop
        {4'b1111, 1'b0, 8'hFB},  // R3 several rise
        {4'b1111, 1'b1, 8'hF0},  // R5 clear
        {4'b1011, 1'b0, 8'hB4}   // R4 ring fall
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
    endtask

    initial begin
        rst = 1'b1; ctl_wr = 1'b0; ctl_wdata = 8'h00; stat_rd = 1'b0;
        modem_in = 4'b1011;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 status", stat_rdata, 8'hB0);
        chk("R1 control", {3'b0, ctl_q}, 8'h08);
        chk("R1 pend", {7'b0, delta_pend}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            modem_in = VEC[i][12:9];
            stat_rd  = VEC[i][8];
            step();
            stat_rd = 1'b0;
            chk("R2-R6 vector", stat_rdata, VEC[i][7:0]);
            chk("R7 pend", {7'b0, delta_pend}, {7'b0, |VEC[i][3:0]});
        end

        // loopback: OUT1 and DTR with loop
        ctl_write(8'h15);
        chk("R9 map a", stat_rdata, 8'h60);
        chk("R10 pend kept", {7'b0, delta_pend}, 8'h01);
        do_read();
        chk("R10 read no clear", {7'b0, delta_pend}, 8'h01);
        ctl_write(8'h1A);
        chk("R9 map b", stat_rdata, 8'h90);
        ctl_write(8'hE5);
        chk("R8 low bits", {3'b0, ctl_q}, 8'h05);
        chk("R10 flags back", stat_rdata, 8'hB4);
        do_read();
        chk("R5 clear after loop", stat_rdata, 8'hB0);

        // reset mid-run
        modem_in = 4'b0000;
        step();
        modem_in = 4'b1011;
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 rerun status", stat_rdata, 8'hB0);
        chk("R1 rerun control", {3'b0, ctl_q}, 8'h08);
        chk("R1 rerun pend", {7'b0, delta_pend}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule